// File: doc/BRIEF.md
# Dual Prescaled Down-Counting Timer

This peripheral holds a configurable number of identical down-counting timers (two by default, 24 bits each) behind one flat register bus made of an address, a write enable, write data and combinational read data. Each timer owns a reload register, a live count register, a mode register and a write-only acknowledge location, and drives one interrupt line. Software loads a count, picks a prescaler and a mode, and receives an interrupt each time the counter expires.

Every timer has a prescaler that divides the clock by 1, 16 or 256. The counter steps down by one on each prescaled tick. A tick that finds the counter already at zero is an expiry. In auto-reload mode the counter then starts again from the reload register. In single-shot mode it parks at zero until software writes a new count. The interrupt is sticky until it is acknowledged.

Top module: `dual_dcount_timer`

## Requirements
- R1: After reset, every register of every timer reads zero, no interrupt is asserted and no timer counts.
- R2: Timer k occupies the 32-byte slot at byte address 0x20*k. Within a slot the byte offsets are: reload 0x0, live count 0x4, mode 0x8, acknowledge 0xC. Address bits 1:0 are ignored. Offsets 0x10 to 0x1F of a slot and the acknowledge offset read zero, and writes to offsets 0x10 to 0x1F change nothing.
- R3: A write to the reload offset stores the low 24 bits of the write data in the reload register. The same value appears in the live count in the next cycle, and the prescaler restarts from its first phase.
- R4: While the run bit is set, the live count drops by exactly one on each prescaled tick. It never changes between ticks.
- R5: Mode bits 3:2 select the prescaler. 0 gives a tick every cycle, 1 gives a tick every 16th cycle and 2 gives a tick every 256th cycle. The reserved value 3 behaves like 0. After a reload write, the first decrement happens 1, 16 or 256 cycles later.
- R6: A tick while the count is zero raises the timer's interrupt. When mode bit 6 (auto-reload) is set, the count is reloaded from the reload register on that same tick.
- R7: With mode bit 6 clear, the count stays at zero after expiry and raises no further interrupt until the reload offset is written again.
- R8: An interrupt stays asserted until any write to that timer's acknowledge offset, whatever the data. If the acknowledge arrives in the same cycle as a new expiry, the interrupt stays set.
- R9: Mode bit 7 is the run bit. Writing a mode word with bit 7 clear (for example zero) freezes the live count at its present value.
- R10: The timers are independent. Writes to one slot never change another timer's registers or interrupt.
- R11: The mode register reads back bits 7, 6 and 3:2 as written. All its other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address (5 + log2 of the timer count) |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 2 | One sticky interrupt per timer |

## Verification
The hardest case to reach is an acknowledge that lands in the exact cycle of a new expiry. The bench arranges it by loading a count of two in auto-reload, divide-by-one mode. It then times the acknowledge write to the third edge after the load, so the expiry and the clear meet. Long-divisor counts, the reserved prescaler code, a stop in the middle of a count and the single-shot parking are all reached by directed sequences. A behavioural model compares the interrupts and the read data of the address under observation on every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   // slot stride of 0x20 bytes, word addressed registers inside a slot
   localparam int SLOT_LSB = 5;
   localparam int WORD_LSB = 2;

   // register index inside a slot (address bits 3:2)
   typedef enum logic [1:0] {
      RG_LOAD  = 2'd0,
      RG_VALUE = 2'd1,
      RG_MODE  = 2'd2,
      RG_ACK   = 2'd3
   } reg_sel_e;

   // prescaler choice held in the mode word
   typedef enum logic [1:0] {
      PS_NONE = 2'd0,
      PS_MID  = 2'd1,
      PS_LONG = 2'd2,
      PS_RSVD = 2'd3
   } psel_e;

   // bit positions of the mode word as seen on the bus
   localparam int BIT_RUN   = 7;
   localparam int BIT_AUTO  = 6;
   localparam int BIT_PS_LO = 2;

   typedef struct packed {
      logic  run;
      logic  auto_rl;
      psel_e psel;
   } mode_t;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
   import tmr_pkg::*;
#(
   parameter int MID_SHIFT  = 4,
   parameter int LONG_SHIFT = 8,
   localparam int PW        = LONG_SHIFT
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  run_i,
   input  psel_e psel_i,
   input  logic  restart_i,
   output logic  tick_o
);

   generate
      if (MID_SHIFT < 1 || MID_SHIFT >= LONG_SHIFT) begin : g_bad_shift
         $error("tmr_prescaler: MID_SHIFT must be in 1..LONG_SHIFT-1");
      end
   endgenerate

   localparam logic [PW-1:0] MID_LIMIT  = PW'((32'd1 << MID_SHIFT) - 32'd1);
   localparam logic [PW-1:0] LONG_LIMIT = {PW{1'b1}};

   logic [PW-1:0] phase_q;
   logic [PW-1:0] limit;

   always_comb begin
      unique case (psel_i)
         PS_MID:  limit = MID_LIMIT;
         PS_LONG: limit = LONG_LIMIT;
         default: limit = '0;   // divide by one, reserved code included
      endcase
   end

   // >= so that a smaller divisor chosen mid-count fires at once instead of wrapping
   assign tick_o = run_i && !restart_i && (phase_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (restart_i || !run_i || tick_o) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + 1'b1;
      end
   end

   // divided modes never tick on two consecutive cycles
   p_no_back2back_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o && (psel_i inside {PS_MID, PS_LONG})
      |=> !tick_o || (psel_i inside {PS_NONE, PS_RSVD}));

   // a restart always leaves the next cycle at the first phase
   p_restart_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> phase_q == '0);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CNT_W      = 24,
   parameter int MID_SHIFT  = 4,
   parameter int LONG_SHIFT = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_load_i,
   input  logic             wr_mode_i,
   input  logic             wr_ack_i,
   input  logic [CNT_W-1:0] wdata_i,
   output logic [CNT_W-1:0] load_o,
   output logic [CNT_W-1:0] value_o,
   output mode_t            mode_o,
   output logic             irq_o
);

   generate
      if (CNT_W < 8) begin : g_bad_cnt
         $error("tmr_channel: CNT_W must cover the mode bits (>= 8)");
      end
   endgenerate

   logic [CNT_W-1:0] load_q;
   logic [CNT_W-1:0] value_q;
   mode_t            mode_q;
   logic             armed_q;
   logic             irq_q;
   logic             tick;
   logic             at_zero;
   logic             expire;

   tmr_prescaler #(
      .MID_SHIFT  (MID_SHIFT),
      .LONG_SHIFT (LONG_SHIFT)
   ) u_prescaler (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (mode_q.run),
      .psel_i    (mode_q.psel),
      .restart_i (wr_load_i),
      .tick_o    (tick)
   );

   assign at_zero = (value_q == '0);
   assign expire  = tick && at_zero && armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_q <= '0;
      end else if (wr_load_i) begin
         load_q <= wdata_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else if (wr_mode_i) begin
         mode_q.run     <= wdata_i[BIT_RUN];
         mode_q.auto_rl <= wdata_i[BIT_AUTO];
         mode_q.psel    <= psel_e'(wdata_i[BIT_PS_LO +: 2]);
      end
   end

   // count, reload and single-shot parking
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value_q <= '0;
         armed_q <= 1'b0;
      end else if (wr_load_i) begin
         value_q <= wdata_i;
         armed_q <= 1'b1;
      end else if (tick) begin
         if (!at_zero) begin
            value_q <= value_q - 1'b1;
         end else if (armed_q) begin
            if (mode_q.auto_rl) begin
               value_q <= load_q;
            end else begin
               armed_q <= 1'b0;
            end
         end
      end
   end

   // expiry wins over an acknowledge in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else if (expire) begin
         irq_q <= 1'b1;
      end else if (wr_ack_i) begin
         irq_q <= 1'b0;
      end
   end

   assign load_o  = load_q;
   assign value_o = value_q;
   assign mode_o  = mode_q;
   assign irq_o   = irq_q;

   p_load_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_load_i |=> value_q == $past(wdata_i));

   p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !at_zero |=> value_q == $past(value_q) - 1'b1);

   p_irq_from_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> $past(tick));

   p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tick && at_zero && armed_q && mode_q.auto_rl |=> value_q == $past(load_q));

   p_oneshot_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tick && at_zero && !mode_q.auto_rl |=> value_q == '0 && !armed_q);

   p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q && !wr_ack_i |=> irq_q);

   p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q.run && !wr_load_i |=> $stable(value_q));

endmodule

// File: rtl/tmr_busdec.sv
module tmr_busdec
   import tmr_pkg::*;
#(
   parameter int N_TIMERS = 2,
   parameter int CNT_W    = 24,
   parameter int DATA_W   = 32,
   localparam int SW      = $clog2(N_TIMERS),
   localparam int AW      = SLOT_LSB + SW
) (
   input  logic [AW-1:0]                  addr_i,
   input  logic                           we_i,
   output logic [N_TIMERS-1:0]            wr_load_o,
   output logic [N_TIMERS-1:0]            wr_mode_o,
   output logic [N_TIMERS-1:0]            wr_ack_o,
   input  logic [N_TIMERS-1:0][CNT_W-1:0] load_i,
   input  logic [N_TIMERS-1:0][CNT_W-1:0] value_i,
   input  mode_t [N_TIMERS-1:0]           mode_i,
   output logic [DATA_W-1:0]              rdata_o
);

   logic [SW-1:0] slot;
   reg_sel_e      word;
   logic          hit;
   logic          unused_byte_lanes;

   assign slot = addr_i[AW-1:SLOT_LSB];
   assign word = reg_sel_e'(addr_i[WORD_LSB +: 2]);
   // upper half of each slot is unmapped; slots past the last timer too
   assign hit  = !addr_i[SLOT_LSB-1] && (int'(slot) < N_TIMERS);
   assign unused_byte_lanes = ^addr_i[WORD_LSB-1:0];

   generate
      for (genvar k = 0; k < N_TIMERS; k++) begin : g_strobe
         logic sel;
         assign sel          = we_i && hit && (slot == SW'(k));
         assign wr_load_o[k] = sel && (word == RG_LOAD);
         assign wr_mode_o[k] = sel && (word == RG_MODE);
         assign wr_ack_o[k]  = sel && (word == RG_ACK);
      end
   endgenerate

   always_comb begin
      rdata_o = '0;
      if (hit) begin
         unique case (word)
            RG_LOAD:  rdata_o = DATA_W'(load_i[slot]);
            RG_VALUE: rdata_o = DATA_W'(value_i[slot]);
            RG_MODE: begin
               rdata_o[BIT_RUN]         = mode_i[slot].run;
               rdata_o[BIT_AUTO]        = mode_i[slot].auto_rl;
               rdata_o[BIT_PS_LO +: 2]  = mode_i[slot].psel;
            end
            default:  rdata_o = '0;
         endcase
      end
   end

endmodule

// File: rtl/dual_dcount_timer.sv
module dual_dcount_timer
   import tmr_pkg::*;
#(
   parameter int N_TIMERS   = 2,
   parameter int CNT_W      = 24,
   parameter int DATA_W     = 32,
   parameter int MID_SHIFT  = 4,
   parameter int LONG_SHIFT = 8,
   localparam int SW        = $clog2(N_TIMERS),
   localparam int AW        = SLOT_LSB + SW
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [AW-1:0]       bus_addr,
   input  logic                bus_we,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic [N_TIMERS-1:0] irq
);

   generate
      if (N_TIMERS < 2) begin : g_bad_n
         $error("dual_dcount_timer: N_TIMERS must be at least 2");
      end
      if (CNT_W > DATA_W) begin : g_bad_dw
         $error("dual_dcount_timer: CNT_W must fit in DATA_W");
      end
      if (DATA_W > CNT_W) begin : g_hi_bits
         logic unused_wdata_hi;
         assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];
      end
   endgenerate

   logic [N_TIMERS-1:0]            wr_load;
   logic [N_TIMERS-1:0]            wr_mode;
   logic [N_TIMERS-1:0]            wr_ack;
   logic [N_TIMERS-1:0][CNT_W-1:0] load_v;
   logic [N_TIMERS-1:0][CNT_W-1:0] value_v;
   mode_t [N_TIMERS-1:0]           mode_v;

   tmr_busdec #(
      .N_TIMERS (N_TIMERS),
      .CNT_W    (CNT_W),
      .DATA_W   (DATA_W)
   ) u_busdec (
      .addr_i    (bus_addr),
      .we_i      (bus_we),
      .wr_load_o (wr_load),
      .wr_mode_o (wr_mode),
      .wr_ack_o  (wr_ack),
      .load_i    (load_v),
      .value_i   (value_v),
      .mode_i    (mode_v),
      .rdata_o   (bus_rdata)
   );

   generate
      for (genvar k = 0; k < N_TIMERS; k++) begin : g_chan
         tmr_channel #(
            .CNT_W      (CNT_W),
            .MID_SHIFT  (MID_SHIFT),
            .LONG_SHIFT (LONG_SHIFT)
         ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_load_i (wr_load[k]),
            .wr_mode_i (wr_mode[k]),
            .wr_ack_i  (wr_ack[k]),
            .wdata_i   (bus_wdata[CNT_W-1:0]),
            .load_o    (load_v[k]),
            .value_o   (value_v[k]),
            .mode_o    (mode_v[k]),
            .irq_o     (irq[k])
         );
      end
   endgenerate

   // a write reaches at most one timer
   p_one_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_load, wr_mode, wr_ack}));

   // after reset release nothing is pending until a bus write has happened
   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> irq == '0);

endmodule

// File: tb/test_dual_dcount_timer.sv
module test_dual_dcount_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  irq;

   always #5 clk = ~clk;

   dual_dcount_timer i_dual_dcount_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   localparam logic [5:0] LD = 6'h00, CV = 6'h04, MD = 6'h08, AK = 6'h0C;
   localparam logic [5:0] T1 = 6'h20;

   int    n_cmp = 0;
   int    n_bad = 0;
   int    cyc = 0;
   bit    done = 1'b0;
   string cur_req = "R1";
   logic [5:0] watch = CV;

   // behavioural reference state
   int m_load [2];
   int m_val  [2];
   int m_run  [2];
   int m_auto [2];
   int m_ps   [2];
   int m_pc   [2];
   int m_arm  [2];
   int m_irq  [2];

   task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, got, exp, $time);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   function automatic logic [31:0] exp_rd(logic [5:0] a);
      int k;
      k = a[5] ? 1 : 0;
      if (a[4]) return 32'h0;
      case (a[3:2])
         2'd0: return 32'(m_load[k]);
         2'd1: return 32'(m_val[k]);
         2'd2: return 32'((m_run[k] << 7) | (m_auto[k] << 6) | (m_ps[k] << 2));
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 2; k++) begin
            m_load[k] = 0; m_val[k] = 0; m_run[k] = 0; m_auto[k] = 0;
            m_ps[k] = 0; m_pc[k] = 0; m_arm[k] = 0; m_irq[k] = 0;
         end
      end else begin
         for (int k = 0; k < 2; k++) begin
            bit wl, wm, wa, tk, ex, mine;
            int lim;
            mine = bus_we && !bus_addr[4] && ((bus_addr[5] ? 1 : 0) == k);
            wl = mine && bus_addr[3:2] == 2'd0;
            wm = mine && bus_addr[3:2] == 2'd2;
            wa = mine && bus_addr[3:2] == 2'd3;
            lim = (m_ps[k] == 1) ? 15 : (m_ps[k] == 2) ? 255 : 0;
            tk = (m_run[k] != 0) && !wl && (m_pc[k] >= lim);
            ex = tk && (m_val[k] == 0) && (m_arm[k] != 0);
            if (wl || m_run[k] == 0 || tk) m_pc[k] = 0;
            else m_pc[k] = m_pc[k] + 1;
            if (ex) m_irq[k] = 1;
            else if (wa) m_irq[k] = 0;
            if (wl) begin
               m_load[k] = int'(bus_wdata[23:0]);
               m_val[k]  = int'(bus_wdata[23:0]);
               m_arm[k]  = 1;
            end else if (tk) begin
               if (m_val[k] != 0) m_val[k] = m_val[k] - 1;
               else if (m_arm[k] != 0) begin
                  if (m_auto[k] != 0) m_val[k] = m_load[k];
                  else m_arm[k] = 0;
               end
            end
            if (wm) begin
               m_run[k]  = bus_wdata[7] ? 1 : 0;
               m_auto[k] = bus_wdata[6] ? 1 : 0;
               m_ps[k]   = int'(bus_wdata[3:2]);
            end
         end
      end
   end

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(cur_req, "irq", {30'b0, irq}, {30'b0, m_irq[1][0], m_irq[0][0]});
         check(cur_req, "rdata", bus_rdata, exp_rd(bus_addr));
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         summary();
         $finish;
      end
   end

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic wait_cyc(int n);
      repeat (n) step();
   endtask

   task automatic wr(logic [5:0] a, logic [31:0] d);
      step();
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      step();
      bus_we = 1'b0; bus_addr = watch;
   endtask

   task automatic look(logic [5:0] a);
      watch = a;
      bus_addr = a;
   endtask

   task automatic chk_rd(string req, string what, logic [31:0] exp);
      @(negedge clk);
      check(req, what, bus_rdata, exp);
   endtask

   task automatic chk_irq(string req, logic [1:0] exp);
      @(negedge clk);
      check(req, "irq pin", {30'b0, irq}, {30'b0, exp});
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1: everything reads zero after reset
      cur_req = "R1";
      for (int i = 0; i < 8; i++) begin
         look((i < 4) ? 6'(i * 4) : 6'(32 + (i - 4) * 4));
         chk_rd("R1", "reset register", 32'h0);
         step();
      end
      chk_irq("R1", 2'b00);

      // R2 / R11: address map and mode read-back
      cur_req = "R2";
      look(MD);
      wr(MD, 32'hFFFF_FF3C);
      chk_rd("R11", "mode readback", 32'h0000_000C);
      look(LD);
      wr(LD, 32'hAB12_3456);
      chk_rd("R2", "reload low 24 bits", 32'h0012_3456);
      look(T1 | LD);
      chk_rd("R10", "other timer reload", 32'h0);
      step();
      look(6'h10);
      wr(6'h10, 32'hFFFF_FFFF);
      chk_rd("R2", "unmapped offset", 32'h0);
      look(6'h37);
      wr(6'h34, 32'h1234_5678);
      chk_rd("R2", "unmapped slot half", 32'h0);
      look(AK);
      chk_rd("R2", "ack offset read", 32'h0);
      look(6'h01);
      chk_rd("R2", "byte lanes ignored", 32'h0012_3456);
      step();

      // R3 / R9: reload reaches the count at once, stopped timer holds
      cur_req = "R3";
      look(CV);
      wr(MD, 32'h0);
      wr(LD, 32'd1000);
      chk_rd("R3", "count after reload", 32'd1000);
      wait_cyc(10);
      chk_rd("R9", "stopped count holds", 32'd1000);

      // R4: divide by one counts every cycle
      cur_req = "R4";
      wr(MD, 32'h80);
      wr(LD, 32'd40);
      wait_cyc(20);
      chk_rd("R4", "count after 20 ticks", 32'd20);
      wait_cyc(30);
      wr(AK, 32'h0);

      // R5: divide by 16
      cur_req = "R5";
      wr(MD, 32'h84);
      wr(LD, 32'd2);
      wait_cyc(15);
      chk_rd("R5", "div16 before first tick", 32'd2);
      step();
      chk_rd("R5", "div16 first tick", 32'd1);
      wait_cyc(40);
      wr(AK, 32'h0);

      // R5: divide by 256
      wr(MD, 32'h88);
      wr(LD, 32'd3);
      wait_cyc(255);
      chk_rd("R5", "div256 before first tick", 32'd3);
      step();
      chk_rd("R5", "div256 first tick", 32'd2);
      wait_cyc(800);
      chk_irq("R6", 2'b01);
      wr(AK, 32'h0);

      // R5: reserved code acts as divide by one
      wr(MD, 32'h8C);
      wr(LD, 32'd5);
      wait_cyc(3);
      chk_rd("R5", "reserved prescaler code", 32'd2);
      wait_cyc(10);
      wr(AK, 32'h0);

      // R6: auto-reload with acknowledges scattered in
      cur_req = "R6";
      wr(MD, 32'hC0);
      wr(LD, 32'd4);
      for (int i = 0; i < 6; i++) begin
         wait_cyc(3 + i);
         wr(AK, 32'hDEAD_BEEF);
      end

      // R7: single-shot parks at zero
      cur_req = "R7";
      wr(MD, 32'h80);
      wr(LD, 32'd3);
      wait_cyc(10);
      wr(AK, 32'h0);
      wait_cyc(50);
      chk_irq("R7", 2'b00);
      chk_rd("R7", "parked count", 32'd0);

      // R8: acknowledge in the expiry cycle keeps the interrupt
      cur_req = "R8";
      wr(MD, 32'hC0);
      wr(LD, 32'd2);
      wait_cyc(1);
      wr(AK, 32'h0);
      chk_irq("R8", 2'b01);
      wr(AK, 32'h5A5A_5A5A);
      chk_irq("R8", 2'b00);
      wr(MD, 32'h0);
      wr(AK, 32'h0);

      // R9: stop in the middle of a count
      cur_req = "R9";
      wr(MD, 32'h80);
      wr(LD, 32'd500);
      wait_cyc(10);
      wr(MD, 32'h0);
      wait_cyc(20);
      chk_rd("R9", "frozen after stop", 32'd488);

      // R10: both timers at once, different settings
      cur_req = "R10";
      look(T1 | CV);
      wr(MD, 32'hC0);
      wr(LD, 32'd6);
      wr(T1 | MD, 32'h84);
      wr(T1 | LD, 32'd2);
      wait_cyc(60);
      chk_irq("R10", 2'b11);
      wr(T1 | AK, 32'h0);
      chk_rd("R10", "timer1 parked", 32'd0);
      wait_cyc(4);
      look(LD);
      chk_rd("R10", "timer0 reload untouched", 32'd6);
      wait_cyc(40);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule